// File: doc/BRIEF.md
# Stepped Instruction Control Decoder

This block sequences a small 8-bit bus-based processor through its instruction cycle. A seven-state stepper moves forward one state per clock. A combinational action table reads the active step together with the instruction byte held in the instruction register and drives three groups of control wires. The first group is the bus-drive enables, which pick the one source that places a byte on the shared bus. The second is the capture strobes, which tell registers to latch the bus. The third is a 3-bit operation select for the ALU.

The first three steps are the same for every instruction. They copy the instruction pointer into the memory address register while the ALU increments it into the accumulator. They then read memory into the instruction register, and finally write the incremented pointer back. Steps four to six depend on the instruction class: ALU operation, register-indirect load, or register jump. When a class needs fewer than three steps, the remaining steps are idle. Step seven does nothing and wraps the stepper back to step one. The registers, ALU, memory and bus are outside this block. It only produces the control wires.

Top module: `stepctl_top`

## Requirements
- R1: After reset, or while `rst_n` is low, the stepper is at step 1 (`step_oh` = 0000001, bit i meaning step i+1). It advances one step per clock, and after step 7 it returns to step 1.
- R2: Vector encodings. In `bus_en`, bits 0-3 are R0-R3, bit 4 is the instruction pointer, bit 5 is the accumulator and bit 6 is memory read. In `bus_set`, bits 0-3 are R0-R3, bit 4 is the memory address register, bit 5 is the instruction pointer, bit 6 is the instruction register, bit 7 is TMP and bit 8 is the accumulator. In step 1, for any instruction, only the instruction pointer drives the bus, the memory address register and the accumulator capture, and `alu_sel` is 111 (increment).
- R3: In step 2, for any instruction, only memory read drives the bus and only the instruction register captures.
- R4: In step 3, for any instruction, only the accumulator drives the bus and only the instruction pointer captures.
- R5: An instruction byte with bit 7 = 1 is an ALU operation. Bits 6:4 are the op, bits 3:2 are RA and bits 1:0 are RB. In step 4, RA drives and TMP captures. In step 5, RB drives, `alu_sel` equals bits 6:4 (ADD = 000) and the accumulator captures. In step 6, the accumulator drives and RB captures.
- R6: Byte 0000_RARB is a load. In step 4, RA drives and the memory address register captures. In step 5, memory read drives and RB captures. Step 6 asserts nothing.
- R7: Byte 0011_00RB is a register jump. In step 4, RB drives and the instruction pointer captures. Steps 5 and 6 assert nothing.
- R8: Step 7 asserts no enable and no capture strobe.
- R9: Any other byte (for example 0001xxxx, 0010xxxx, 01xxxxxx, or 0011 with nonzero bits 3:2) leaves steps 4 to 6 completely idle.
- R10: At most one bit of `bus_en` is high in any cycle.
- R11: `alu_sel` is 000 in every step that does not select an ALU operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| ir_byte | input | 8 | Instruction byte currently held in the instruction register |
| step_oh | output | 7 | One-hot active step, bit 0 = step 1 |
| bus_en | output | 7 | One-hot-or-zero bus drive enables |
| bus_set | output | 9 | Capture strobes |
| alu_sel | output | 3 | ALU operation select |

## Verification
The hardest situations to reach from the ports are instruction bytes that sit one bit away from a legal encoding, such as a jump pattern with a nonzero RA field or a byte with bit 7 clear and bits 6:4 nonzero. These must fall back to idle execute steps without disturbing the fetch steps. The stimulus holds each such byte steady through a full seven-step pass and compares every step against the idle pattern. The other hard case is a reset in the middle of execution. It is reached by pulling `rst_n` low at step 5 of an ALU operation and confirming that the stepper restarts a clean fetch at step 1.

// File: rtl/stepctl_pkg.sv
package stepctl_pkg;
  localparam int GPRS    = 4;
  localparam int GPR_W   = $clog2(GPRS);
  localparam int INSTR_W = 8;
  localparam int ALU_W   = 3;
  localparam int STEPS   = 7;
  localparam int STEP_W  = $clog2(STEPS);

  localparam int EN_IAR = GPRS;
  localparam int EN_ACC = GPRS + 1;
  localparam int EN_RAM = GPRS + 2;
  localparam int EN_W   = GPRS + 3;

  localparam int SET_MAR = GPRS;
  localparam int SET_IAR = GPRS + 1;
  localparam int SET_IR  = GPRS + 2;
  localparam int SET_TMP = GPRS + 3;
  localparam int SET_ACC = GPRS + 4;
  localparam int SET_W   = GPRS + 5;

  localparam logic [ALU_W-1:0] ALU_ADD = 3'b000;
  localparam logic [ALU_W-1:0] ALU_INC = 3'b111;

  typedef enum logic [1:0] {
    K_IDLE = 2'd0,
    K_ALU  = 2'd1,
    K_LOAD = 2'd2,
    K_JMPR = 2'd3
  } instr_kind_e;
endpackage

// File: rtl/stepctl_stepper.sv
module stepctl_stepper
  import stepctl_pkg::*;
#(
  parameter int N_STEPS = STEPS,
  localparam int SW     = $clog2(N_STEPS)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [SW-1:0]   step_idx,
  output logic [N_STEPS-1:0] step_oh
);
  localparam logic [SW-1:0] LAST = SW'(N_STEPS - 1);

  logic [SW-1:0] step_q, step_d;

  always_comb begin
    if (step_q == LAST) step_d = '0;
    else                step_d = step_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end

  assign step_idx = step_q;

  for (genvar i = 0; i < N_STEPS; i++) begin : g_oh
    assign step_oh[i] = (step_q == SW'(i));
  end

  assert_step_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == LAST) |=> (step_q == '0));
  assert_step_adv_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q != LAST) |=> (step_q == $past(step_q) + 1'b1));
endmodule

// File: rtl/stepctl_instr_decode.sv
module stepctl_instr_decode
  import stepctl_pkg::*;
#(
  parameter int IW = INSTR_W
) (
  input  logic [IW-1:0]    ir_byte,
  output instr_kind_e      kind,
  output logic [GPR_W-1:0] ra,
  output logic [GPR_W-1:0] rb,
  output logic [ALU_W-1:0] op
);
  assign ra = ir_byte[2*GPR_W-1:GPR_W];
  assign rb = ir_byte[GPR_W-1:0];
  assign op = ir_byte[IW-2:IW-1-ALU_W];

  always_comb begin
    if (ir_byte[IW-1])                          kind = K_ALU;
    else if (ir_byte[IW-1:4] == 4'b0000)        kind = K_LOAD;
    else if (ir_byte[IW-1:2] == 6'b0011_00)     kind = K_JMPR;
    else                                        kind = K_IDLE;
  end
endmodule

// File: rtl/stepctl_action_table.sv
module stepctl_action_table
  import stepctl_pkg::*;
(
  input  logic [STEP_W-1:0] step_idx,
  input  instr_kind_e       kind,
  input  logic [GPR_W-1:0]  ra,
  input  logic [GPR_W-1:0]  rb,
  input  logic [ALU_W-1:0]  op,
  output logic [EN_W-1:0]   bus_en,
  output logic [SET_W-1:0]  bus_set,
  output logic [ALU_W-1:0]  alu_sel
);
  always_comb begin
    bus_en  = '0;
    bus_set = '0;
    alu_sel = ALU_ADD;
    case (step_idx)
      3'd0: begin
        bus_en[EN_IAR]   = 1'b1;
        bus_set[SET_MAR] = 1'b1;
        bus_set[SET_ACC] = 1'b1;
        alu_sel          = ALU_INC;
      end
      3'd1: begin
        bus_en[EN_RAM]  = 1'b1;
        bus_set[SET_IR] = 1'b1;
      end
      3'd2: begin
        bus_en[EN_ACC]   = 1'b1;
        bus_set[SET_IAR] = 1'b1;
      end
      3'd3: begin
        case (kind)
          K_ALU:  begin bus_en[ra] = 1'b1; bus_set[SET_TMP] = 1'b1; end
          K_LOAD: begin bus_en[ra] = 1'b1; bus_set[SET_MAR] = 1'b1; end
          K_JMPR: begin bus_en[rb] = 1'b1; bus_set[SET_IAR] = 1'b1; end
          default: ;
        endcase
      end
      3'd4: begin
        case (kind)
          K_ALU: begin
            bus_en[rb]       = 1'b1;
            bus_set[SET_ACC] = 1'b1;
            alu_sel          = op;
          end
          K_LOAD: begin bus_en[EN_RAM] = 1'b1; bus_set[rb] = 1'b1; end
          default: ;
        endcase
      end
      3'd5: begin
        if (kind == K_ALU) begin
          bus_en[EN_ACC] = 1'b1;
          bus_set[rb]    = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/stepctl_top.sv
module stepctl_top
  import stepctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] ir_byte,
  output logic [STEPS-1:0]   step_oh,
  output logic [EN_W-1:0]    bus_en,
  output logic [SET_W-1:0]   bus_set,
  output logic [ALU_W-1:0]   alu_sel
);
  logic [STEP_W-1:0] step_idx;
  instr_kind_e       kind;
  logic [GPR_W-1:0]  ra, rb;
  logic [ALU_W-1:0]  op;

  stepctl_stepper #(.N_STEPS(STEPS)) u_stepper (
    .clk(clk), .rst_n(rst_n), .step_idx(step_idx), .step_oh(step_oh)
  );

  stepctl_instr_decode #(.IW(INSTR_W)) u_decode (
    .ir_byte(ir_byte), .kind(kind), .ra(ra), .rb(rb), .op(op)
  );

  stepctl_action_table u_table (
    .step_idx(step_idx), .kind(kind), .ra(ra), .rb(rb), .op(op),
    .bus_en(bus_en), .bus_set(bus_set), .alu_sel(alu_sel)
  );

  assert_bus_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_en));
  assert_fetch_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_oh[0] |-> (alu_sel == ALU_INC) && bus_en[EN_IAR] && bus_set[SET_ACC]);
  assert_ir_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_oh[1] |-> bus_en[EN_RAM] && bus_set[SET_IR]);
  assert_last_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step_oh[STEPS-1] |-> (bus_en == '0) && (bus_set == '0));
  assert_alu_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_sel != ALU_ADD) |-> bus_set[SET_ACC]);
endmodule

// File: tb/stepctl_top_test.sv
module stepctl_top_test;
  localparam int CLK_P = 10;
  localparam int WDOG  = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ir_byte = 8'h00;
  logic [6:0] step_oh;
  logic [6:0] bus_en;
  logic [8:0] bus_set;
  logic [2:0] alu_sel;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  stepctl_top uut (
    .clk(clk), .rst_n(rst_n), .ir_byte(ir_byte),
    .step_oh(step_oh), .bus_en(bus_en), .bus_set(bus_set), .alu_sel(alu_sel)
  );

  task automatic check(input string tag, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  // Expected action set from the requirements; s = 1..7
  task automatic model(input int s, input logic [7:0] ir,
                       output logic [6:0] e, output logic [8:0] st,
                       output logic [2:0] a, output string tag);
    logic [1:0] ra, rb;
    int k; // 0 idle, 1 alu, 2 load, 3 jump
    ra = ir[3:2]; rb = ir[1:0];
    if (ir[7]) k = 1;
    else if (ir[7:4] == 4'b0000) k = 2;
    else if (ir[7:2] == 6'b001100) k = 3;
    else k = 0;
    e = '0; st = '0; a = 3'b000;
    tag = (k == 1) ? "R5" : (k == 2) ? "R6" : (k == 3) ? "R7" : "R9";
    case (s)
      1: begin e[4] = 1; st[4] = 1; st[8] = 1; a = 3'b111; tag = "R2"; end
      2: begin e[6] = 1; st[6] = 1; tag = "R3"; end
      3: begin e[5] = 1; st[5] = 1; tag = "R4"; end
      4: if (k == 1) begin e[ra] = 1; st[7] = 1; end
         else if (k == 2) begin e[ra] = 1; st[4] = 1; end
         else if (k == 3) begin e[rb] = 1; st[5] = 1; end
      5: if (k == 1) begin e[rb] = 1; st[8] = 1; a = ir[6:4]; end
         else if (k == 2) begin e[6] = 1; st[rb] = 1; end
      6: if (k == 1) begin e[5] = 1; st[rb] = 1; end
      default: tag = "R8";
    endcase
  endtask

  task automatic check_step(input int s, input logic [7:0] ir);
    logic [6:0] e; logic [8:0] st; logic [2:0] a; string tag;
    model(s, ir, e, st, a, tag);
    check("R1", "step", 16'(step_oh), 16'(7'b1 << (s - 1)));
    check(tag, "bus_en", 16'(bus_en), 16'(e));
    check(tag, "bus_set", 16'(bus_set), 16'(st));
    check((a == 3'b000 && s != 5) ? "R11" : tag, "alu_sel", 16'(alu_sel), 16'(a));
    check("R10", "en_count", 16'($countones(bus_en) <= 1), 16'd1);
  endtask

  // Called at a negedge with the stepper at step 1
  task automatic run_instr(input logic [7:0] ir);
    ir_byte = ir;
    for (int s = 1; s <= 7; s++) begin
      #1;
      check_step(s, ir);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R1", "step_in_reset", 16'(step_oh), 16'h0001);
    check("R2", "en_in_reset", 16'(bus_en), 16'h0010);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_add();       // ADD R2,R3 and ADD R0,R0
    run_instr(8'b1000_1011);
    run_instr(8'b1000_0000);
  endtask

  task automatic t_alu_ops();   // other ALU ops pass bits 6:4 through
    run_instr(8'b1101_0100);
    run_instr(8'b1111_1110);
  endtask

  task automatic t_load();
    run_instr(8'b0000_0001);
    run_instr(8'b0000_1110);
  endtask

  task automatic t_jmpr();
    run_instr(8'b0011_0000);
    run_instr(8'b0011_0010);
  endtask

  task automatic t_undef();
    run_instr(8'b0011_0100);
    run_instr(8'b0001_1111);
    run_instr(8'b0010_1010);
    run_instr(8'b0110_0000);
  endtask

  task automatic t_mid_reset(); // R1: reset during step 5 restarts fetch
    ir_byte = 8'b1000_1011;
    repeat (4) @(negedge clk);
    #1;
    check("R1", "before_reset", 16'(step_oh), 16'h0010);
    rst_n = 1'b0;
    #1;
    check("R1", "async_reset", 16'(step_oh), 16'h0001);
    @(negedge clk);
    rst_n = 1'b1;
    run_instr(8'b1000_1011);
  endtask

  initial begin
    t_reset();
    t_add();
    t_alu_ops();
    t_load();
    t_jmpr();
    t_undef();
    t_mid_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule